// File: doc/BRIEF.md
# Sampling-Phase Programming Sequencer

This block loads a new sampling-clock phase, one of sixteen, into the control word of a tapped delay line. The caller pulses `start` with a phase index. The sequencer then runs a fixed handshake on that word. It turns off the clock output and the recovery loop, and waits for the output-enable status to fall. It writes the phase as a Gray code into the select field. It turns the output back on and waits for the status to rise. Last, it hands selection back to the clock-data recovery logic.

Every change to the control word is a read-modify-write. The block reads the word's current value on `cfgRdata` and puts the changed word on `cfgWdata` with `cfgWe` in the same cycle, so any bit it does not own is kept. Each wait samples the status once per poll tick. A prescaler makes that tick, nominally 1 µs, from the system clock. The number of samples per wait is bounded. If a wait runs out, the sequence ends with an error pulse and no further writes.

Top module: `dly_phase_prog`

## Requirements
- R1: During and right after reset, `busy`, `done`, `tmoErr` and `cfgWe` are all 0.
- R2: The select field is `cfgWdata[23:20]`. It receives the Gray code of the phase index, and the whole field is overwritten. The codes for indices 0 to 15 are 0,1,3,2,6,7,5,4,C,D,F,E,A,B,9,8 (hex).
- R3: The first write comes one cycle after an accepted start. It clears bit 17 (recovery enable) and bit 18 (output enable), and sets bit 16 (line enable) and bit 19 (external select). All other bits keep their read value.
- R4: The select write happens only after the status has been sampled as 0.
- R5: After the select write, a separate write sets bit 18. The sequencer then waits until the status is sampled as 1.
- R6: The last write sets bit 17 and clears bit 19. A successful run makes exactly four writes.
- R7: In each wait, the status is sampled in the first cycle of the wait and then every `TICK_DIV` cycles, at most `POLL_MAX` times. A match on the last allowed sample still counts as success.
- R8: If the last allowed sample does not match, `tmoErr` is high for exactly the next cycle. No further write is made, and `busy` falls in the cycle after that.
- R9: On success, `done` is high for one cycle, 7 + (k1+k2)·`TICK_DIV` cycles after the start cycle. Here k1 and k2 are the number of failed samples in the two waits. `done` and `tmoErr` are never high together.
- R10: `busy` is high from the cycle after an accepted start through the cycle of `done` or `tmoErr`. A start that arrives while `busy` is high, including in the `done` cycle, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to program a phase (one cycle) |
| phaseIdx | input | 4 | Phase index 0..15, sampled with start |
| cfgRdata | input | 32 | Current value of the delay-line control word |
| cfgWdata | output | 32 | Modified control word |
| cfgWe | output | 1 | Write strobe for cfgWdata |
| ckOutSts | input | 1 | Output-enable status reported by the delay line |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle success pulse |
| tmoErr | output | 1 | One-cycle timeout pulse |

## Verification
Completion and a new request can fall in the same cycle. The bench provokes this by raising `start` in the exact cycle in which `done` is seen high. It then judges that `busy` is low in the following cycle and that no write appears. A later start in idle is judged to run a full, correct sequence. A second case is a start pulse in the middle of a long wait: the final select field must still hold the first phase's code, and only one `done` may appear. A status that settles exactly on the last allowed sample, against one cycle later, is what separates success from timeout.

// File: rtl/dps_pkg.sv
package dps_pkg;
  localparam int WORD_W    = 32;
  localparam int BIT_LNEN  = 16;
  localparam int BIT_RCEN  = 17;
  localparam int BIT_OUTEN = 18;
  localparam int BIT_XSEL  = 19;
  localparam int SEL_LSB   = 20;
  localparam int SEL_W     = 4;

  typedef enum logic [2:0] {
    STEP_NONE, STEP_DIS, STEP_SEL, STEP_EN, STEP_CDR
  } stepE;

  typedef struct packed {
    logic latchPhase;
    logic timerClr;
    stepE step;
  } seqStrbT;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DIS, ST_WLO, ST_SEL, ST_EN, ST_WHI, ST_CDR, ST_FIN, ST_FAIL
  } seqStateE;
endpackage

// File: rtl/dps_dpath.sv
module dps_dpath
  import dps_pkg::*;
#(
  parameter int TICK_DIV = 100
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrbT            strb,
  input  logic [SEL_W-1:0]   phaseIdx,
  input  logic [WORD_W-1:0]  cfgRdata,
  output logic [WORD_W-1:0]  cfgWdata,
  output logic               cfgWe,
  output logic               pollTick
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);

  logic [SEL_W-1:0] phaseReg;
  logic [SEL_W-1:0] grayCode;
  logic [PW-1:0]    preCnt;

  always_ff @(posedge clk) begin
    if (!rstN) phaseReg <= '0;
    else if (strb.latchPhase) phaseReg <= phaseIdx;
  end

  // binary to reflected Gray, one XOR per bit
  for (genvar g = 0; g < SEL_W; g++) begin : g_gray
    if (g == SEL_W - 1) begin : g_top
      assign grayCode[g] = phaseReg[g];
    end else begin : g_low
      assign grayCode[g] = phaseReg[g] ^ phaseReg[g+1];
    end
  end

  // poll tick prescaler, restarted before each wait
  generate
    if (TICK_DIV > 1) begin : g_pre
      always_ff @(posedge clk) begin
        if (!rstN || strb.timerClr) preCnt <= '0;
        else if (preCnt == PRE_LAST) preCnt <= '0;
        else preCnt <= preCnt + 1'b1;
      end
      assign pollTick = (preCnt == '0);
    end else begin : g_nopre
      always_ff @(posedge clk) preCnt <= '0;
      assign pollTick = 1'b1;
    end
  endgenerate

  always_comb begin
    cfgWdata = cfgRdata;
    cfgWe    = 1'b1;
    unique case (strb.step)
      STEP_DIS: begin
        cfgWdata[BIT_RCEN]  = 1'b0;
        cfgWdata[BIT_OUTEN] = 1'b0;
        cfgWdata[BIT_XSEL]  = 1'b1;
        cfgWdata[BIT_LNEN]  = 1'b1;
      end
      STEP_SEL: cfgWdata[SEL_LSB +: SEL_W] = grayCode;
      STEP_EN:  cfgWdata[BIT_OUTEN] = 1'b1;
      STEP_CDR: begin
        cfgWdata[BIT_RCEN] = 1'b1;
        cfgWdata[BIT_XSEL] = 1'b0;
      end
      default: cfgWe = 1'b0;
    endcase
  end

  a_r2_phase_held: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step != STEP_NONE) |-> !strb.latchPhase);
endmodule

// File: rtl/dps_ctrl.sv
module dps_ctrl
  import dps_pkg::*;
#(
  parameter int POLL_MAX = 50
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    ckOutSts,
  input  logic    pollTick,
  output seqStrbT strb,
  output logic    busy,
  output logic    done,
  output logic    tmoErr
);
  localparam int CW = $clog2(POLL_MAX + 1);
  localparam logic [CW-1:0] POLL_LAST = CW'(POLL_MAX - 1);

  seqStateE state, stateNxt;
  logic [CW-1:0] pollCnt;
  logic pollInc;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else state <= stateNxt;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.timerClr) pollCnt <= '0;
    else if (pollInc) pollCnt <= pollCnt + 1'b1;
  end

  always_comb begin
    stateNxt = state;
    strb     = '{latchPhase: 1'b0, timerClr: 1'b0, step: STEP_NONE};
    pollInc  = 1'b0;
    unique case (state)
      ST_IDLE: if (start) begin
        strb.latchPhase = 1'b1;
        stateNxt = ST_DIS;
      end
      ST_DIS: begin
        strb.step = STEP_DIS;
        strb.timerClr = 1'b1;
        stateNxt = ST_WLO;
      end
      ST_WLO: if (pollTick) begin
        if (!ckOutSts) stateNxt = ST_SEL;
        else if (pollCnt == POLL_LAST) stateNxt = ST_FAIL;
        else pollInc = 1'b1;
      end
      ST_SEL: begin
        strb.step = STEP_SEL;
        stateNxt = ST_EN;
      end
      ST_EN: begin
        strb.step = STEP_EN;
        strb.timerClr = 1'b1;
        stateNxt = ST_WHI;
      end
      ST_WHI: if (pollTick) begin
        if (ckOutSts) stateNxt = ST_CDR;
        else if (pollCnt == POLL_LAST) stateNxt = ST_FAIL;
        else pollInc = 1'b1;
      end
      ST_CDR: begin
        strb.step = STEP_CDR;
        stateNxt = ST_FIN;
      end
      ST_FIN:  stateNxt = ST_IDLE;
      ST_FAIL: stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign busy   = (state != ST_IDLE);
  assign done   = (state == ST_FIN);
  assign tmoErr = (state == ST_FAIL);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (strb.step == STEP_NONE));
  a_r4_sel_after_low: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step == STEP_SEL) |-> !$past(ckOutSts));
  a_r6_cdr_after_high: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step == STEP_CDR) |-> $past(ckOutSts));
  a_r7_poll_bound: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt < CW'(POLL_MAX));
  a_r8_err_pulse: assert property (@(posedge clk) disable iff (!rstN)
    tmoErr |=> (!tmoErr && !busy));
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(done && tmoErr));
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done && !tmoErr && start) |=> busy);
endmodule

// File: rtl/dly_phase_prog.sv
module dly_phase_prog
  import dps_pkg::*;
#(
  parameter int TICK_DIV = 100,
  parameter int POLL_MAX = 50
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [3:0]  phaseIdx,
  input  logic [31:0] cfgRdata,
  output logic [31:0] cfgWdata,
  output logic        cfgWe,
  input  logic        ckOutSts,
  output logic        busy,
  output logic        done,
  output logic        tmoErr
);
  seqStrbT strb;
  logic    pollTick;

  dps_ctrl #(.POLL_MAX(POLL_MAX)) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .ckOutSts(ckOutSts),
    .pollTick(pollTick), .strb(strb), .busy(busy), .done(done),
    .tmoErr(tmoErr)
  );

  dps_dpath #(.TICK_DIV(TICK_DIV)) i_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .phaseIdx(phaseIdx),
    .cfgRdata(cfgRdata), .cfgWdata(cfgWdata), .cfgWe(cfgWe),
    .pollTick(pollTick)
  );
endmodule

// File: tb/test_dly_phase_prog.sv
module test_dly_phase_prog;
  localparam int CLK_PERIOD = 10;
  localparam int DIV  = 4;
  localparam int POLL = 5;

  typedef struct packed {
    logic [31:0] init;
    logic [3:0]  ph;
    logic [5:0]  lat;
    logic        stuck;
  } vecT;

  localparam vecT VECS [7] = '{
    '{32'h0000_0000, 4'd0,  6'd0,  1'b0},
    '{32'hFFFF_FFFF, 4'd15, 6'd3,  1'b0},
    '{32'h1234_5678, 4'd5,  6'd7,  1'b0},
    '{32'h0004_0000, 4'd10, 6'd16, 1'b0},
    '{32'h00F0_0000, 4'd2,  6'd1,  1'b0},
    '{32'hA5A5_A5A5, 4'd12, 6'd17, 1'b0},
    '{32'h0000_0000, 4'd7,  6'd0,  1'b1}
  };
  localparam logic [3:0] GRAY_TBL [16] = '{4'h0, 4'h1, 4'h3, 4'h2, 4'h6, 4'h7,
    4'h5, 4'h4, 4'hC, 4'hD, 4'hF, 4'hE, 4'hA, 4'hB, 4'h9, 4'h8};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [3:0] phaseIdx = '0;
  logic [31:0] ctlReg, cfgWdata, loadVal;
  logic loadEn = 1'b0;
  logic cfgWe, ckOutSts, busy, done, tmoErr;
  logic [31:0] hist;
  int latSel = 0;
  logic stuckLo = 1'b0;
  int nChk = 0, nErr = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk) begin
    if (loadEn) ctlReg <= loadVal;
    else if (cfgWe) ctlReg <= cfgWdata;
    hist <= {hist[30:0], ctlReg[18]};
  end
  assign ckOutSts = stuckLo ? 1'b0 : (latSel == 0 ? ctlReg[18] : hist[latSel-1]);

  dly_phase_prog #(.TICK_DIV(DIV), .POLL_MAX(POLL)) i_dly_phase_prog (
    .clk(clk), .rstN(rstN), .start(start), .phaseIdx(phaseIdx),
    .cfgRdata(ctlReg), .cfgWdata(cfgWdata), .cfgWe(cfgWe),
    .ckOutSts(ckOutSts), .busy(busy), .done(done), .tmoErr(tmoErr)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] stepWord(input logic [31:0] w0,
                                           input logic [3:0] ph, input int upto);
    logic [31:0] w = w0;
    if (upto >= 1) begin w[17] = 0; w[18] = 0; w[19] = 1; w[16] = 1; end
    if (upto >= 2) w[23:20] = GRAY_TBL[ph];
    if (upto >= 3) w[18] = 1;
    if (upto >= 4) begin w[17] = 1; w[19] = 0; end
    return w;
  endfunction

  task automatic loadWord(input logic [31:0] v, input int lat, input logic stk);
    @(negedge clk);
    loadVal = v; loadEn = 1'b1; latSel = lat; stuckLo = stk;
    @(negedge clk);
    loadEn = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  // pulse start, return cycles to done/err and number of writes seen
  task automatic runSeq(input logic [3:0] ph, output int nEnd, output int nWr,
                        output logic sawDone, output logic busyOk);
    int n = 0;
    nWr = 0; sawDone = 0; nEnd = -1; busyOk = 1;
    start = 1'b1; phaseIdx = ph;
    @(negedge clk);
    start = 1'b0;
    while (nEnd < 0 && n < 300) begin
      n++;
      if (cfgWe) nWr++;
      if (!busy) busyOk = 0;
      if (done || tmoErr) begin nEnd = n; sawDone = done; end
      if (nEnd < 0) @(negedge clk);
    end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (cfgWe) nWr++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    nErr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nChk, nErr);
    $finish;
  end

  initial begin
    int nEnd, nWr, k1, k2, expEnd, expWr, stg;
    logic sawDone, busyOk, expDone;
    ctlReg = '0; hist = '0; loadVal = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !tmoErr && !cfgWe, "R1 reset outputs",
        {busy, done, tmoErr, cfgWe}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !tmoErr && !cfgWe, "R1 after reset",
        {busy, done, tmoErr, cfgWe}, 0);

    // vector table: R2 R3 R4 R5 R6 R7 R8 R9
    for (int v = 0; v < 7; v++) begin
      loadWord(VECS[v].init, int'(VECS[v].lat), VECS[v].stuck);
      k1 = VECS[v].init[18] ? (int'(VECS[v].lat) + DIV - 1) / DIV : 0;
      k2 = VECS[v].stuck ? POLL : (int'(VECS[v].lat) + DIV - 1) / DIV;
      if (k1 >= POLL) begin
        expDone = 0; expEnd = 2 + (POLL-1)*DIV + 1; expWr = 1; stg = 1;
      end else if (k2 >= POLL) begin
        expDone = 0; expEnd = 5 + k1*DIV + (POLL-1)*DIV + 1; expWr = 3; stg = 3;
      end else begin
        expDone = 1; expEnd = 7 + (k1+k2)*DIV; expWr = 4; stg = 4;
      end
      runSeq(VECS[v].ph, nEnd, nWr, sawDone, busyOk);
      chk(sawDone == expDone, expDone ? "R9 done outcome" : "R8 timeout outcome",
          32'(sawDone), 32'(expDone));
      chk(nEnd == expEnd, expDone ? "R9 R7 done cycle" : "R8 R7 error cycle",
          nEnd, expEnd);
      chk(nWr == expWr, expDone ? "R6 write count" : "R8 no further writes",
          nWr, expWr);
      chk(ctlReg == stepWord(VECS[v].init, VECS[v].ph, stg),
          "R2 R3 R5 R6 final word", ctlReg, stepWord(VECS[v].init, VECS[v].ph, stg));
      chk(busyOk && !busy, "R10 busy window", {busyOk, busy}, 32'h2);
    end

    // R4: select field untouched while status still high (long latency, probe mid-wait)
    loadWord(32'h0F04_0000, 12, 1'b0);
    start = 1'b1; phaseIdx = 4'd6;
    @(negedge clk); start = 1'b0;
    repeat (6) @(negedge clk);
    chk(ctlReg[23:20] == 4'h0 && ctlReg[18] == 0, "R4 select held during wait",
        ctlReg[23:20], 0);
    while (!done && !tmoErr) @(negedge clk);
    chk(ctlReg[23:20] == GRAY_TBL[6], "R2 gray 6", ctlReg[23:20], GRAY_TBL[6]);

    // R10: start mid-sequence ignored
    loadWord(32'h0004_0000, 8, 1'b0);
    start = 1'b1; phaseIdx = 4'd3;
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    start = 1'b1; phaseIdx = 4'd9;
    @(negedge clk); start = 1'b0;
    begin
      int nDone = 0;
      for (int k = 0; k < 60; k++) begin
        if (done) nDone++;
        @(negedge clk);
      end
      chk(nDone == 1, "R10 single done", nDone, 1);
    end
    chk(ctlReg[23:20] == GRAY_TBL[3], "R10 first phase kept", ctlReg[23:20], GRAY_TBL[3]);

    // R10: start in the done cycle ignored, later start accepted
    loadWord(32'h0000_0000, 0, 1'b0);
    start = 1'b1; phaseIdx = 4'd1;
    @(negedge clk); start = 1'b0;
    while (!done) @(negedge clk);
    start = 1'b1; phaseIdx = 4'd14;
    @(negedge clk); start = 1'b0;
    chk(!busy && !cfgWe, "R10 start during done ignored", {busy, cfgWe}, 0);
    chk(ctlReg[23:20] == GRAY_TBL[1], "R10 word after ignored start",
        ctlReg[23:20], GRAY_TBL[1]);
    runSeq(4'd14, nEnd, nWr, sawDone, busyOk);
    chk(sawDone && nEnd == 7, "R9 idle start accepted", nEnd, 7);
    chk(ctlReg[23:20] == GRAY_TBL[14], "R2 gray 14", ctlReg[23:20], GRAY_TBL[14]);

    $display("Simulation finished: %0d checks, %0d errors", nChk, nErr);
    $finish;
  end
endmodule